// File: doc/BRIEF.md
# Selectable Clock Divider Pair

This block derives two related clocks from one fast reference clock. The reference runs at twice the nominal input rate. A 2-bit ratio code picks one of four behaviours: stopped, double rate, divide by five, or divide by three, each counted against the nominal input. The primary output carries the chosen rate. The secondary output always runs at half the primary, and its rising edges fall on primary rising edges.

Both outputs come from one shared counter. Every half-period is a whole number of reference cycles, so the duty cycle is exactly 50%. In double-rate mode the primary is the reference itself, passed through a gate that only changes while the reference is low.

The ratio code is synchronized before use. A new code is adopted only at the close of a secondary period, when both outputs are low, so switching never produces a short pulse. An active-low enable releases both pins to high impedance.

Top module: `clkdiv_pair`

## Requirements
- R1: Code 2'b00 (off) holds both outputs low and keeps the counter at zero while the code stays in force.
- R2: Code 2'b01 (double rate) makes the primary equal to the reference, high for half a reference cycle and low for half a reference cycle. The secondary is high for one reference cycle and low for one.
- R3: Code 2'b10 (divide by five) gives a primary that is 5 reference cycles high and 5 low, and a secondary that is 10 high and 10 low.
- R4: Code 2'b11 (divide by three) gives a primary that is 3 reference cycles high and 3 low, and a secondary that is 6 high and 6 low.
- R5: Each secondary rising edge coincides with a primary rising edge, and the secondary rises on every second primary rising edge.
- R6: While oe_ni is 1, both outputs are high impedance whatever the code.
- R7: A code change is adopted only at the end of a secondary period, with both outputs low. No high or low phase of either output is shorter or longer than a phase of the old ratio or of the new ratio.
- R8: The code passes two synchronizing flops. A code driven between edges from the off state makes both outputs rise together at the third reference rising edge after it is driven.
- R9: A low rst_ni immediately forces both outputs low and the mode to off. After release, with a running code applied, both outputs rise together at the third reference rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast reference clock, twice the nominal input rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 2 | Ratio code: 00 off, 01 double rate, 10 divide by five, 11 divide by three |
| oe_ni | input | 1 | Output enable, active low; 1 puts both outputs in high impedance |
| pri_o | output | 1 | Primary clock |
| sec_o | output | 1 | Secondary clock, half the primary rate |

## Verification
A wrong count or a wrong mode register shows within one secondary period. It appears as a high or low phase of the wrong length, or as a secondary edge with no matching primary edge. Measuring every phase in half-reference-cycle samples catches it at the first bad phase. A switch taken at the wrong moment shows as a runt phase in the cycles right after a code change. A bad synchronizer depth shows as a first rising edge one cycle early or late when leaving the off state or reset.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_X2   = 2'b01,
    MODE_SLOW = 2'b10,
    MODE_FAST = 2'b11
  } mode_e;
endpackage

// File: rtl/clkdiv_sync.sv
module clkdiv_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[g] <= '0;
        else         stage_q[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[g] <= '0;
        else         stage_q[g] <= stage_q[g-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core
  import clkdiv_pkg::*;
#(
  parameter int HALF_SLOW = 5,
  parameter int HALF_FAST = 3,
  parameter int CW        = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  mode_e         mode_req_i,
  output mode_e         mode_q_o,
  output logic [CW-1:0] cnt_q_o,
  output logic          pri_q_o,
  output logic          sec_q_o,
  output logic          x2_next_o
);
  localparam logic [CW-1:0] H_S    = CW'(HALF_SLOW);
  localparam logic [CW-1:0] TWO_S  = CW'(2 * HALF_SLOW);
  localparam logic [CW-1:0] THR_S  = CW'(3 * HALF_SLOW);
  localparam logic [CW-1:0] LAST_S = CW'(4 * HALF_SLOW - 1);
  localparam logic [CW-1:0] H_F    = CW'(HALF_FAST);
  localparam logic [CW-1:0] TWO_F  = CW'(2 * HALF_FAST);
  localparam logic [CW-1:0] THR_F  = CW'(3 * HALF_FAST);
  localparam logic [CW-1:0] LAST_F = CW'(4 * HALF_FAST - 1);
  localparam logic [CW-1:0] LAST_X = CW'(1);

  function automatic logic [CW-1:0] last_of(mode_e m);
    case (m)
      MODE_X2:   last_of = LAST_X;
      MODE_SLOW: last_of = LAST_S;
      MODE_FAST: last_of = LAST_F;
      default:   last_of = '0;
    endcase
  endfunction

  // registered primary level; double-rate primary comes from the clock gate
  function automatic logic pri_of(mode_e m, logic [CW-1:0] c);
    case (m)
      MODE_SLOW: pri_of = (c < H_S) || ((c >= TWO_S) && (c < THR_S));
      MODE_FAST: pri_of = (c < H_F) || ((c >= TWO_F) && (c < THR_F));
      default:   pri_of = 1'b0;
    endcase
  endfunction

  function automatic logic sec_of(mode_e m, logic [CW-1:0] c);
    case (m)
      MODE_X2:   sec_of = (c == '0);
      MODE_SLOW: sec_of = (c < TWO_S);
      MODE_FAST: sec_of = (c < TWO_F);
      default:   sec_of = 1'b0;
    endcase
  endfunction

  mode_e         mode_q, mode_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          pri_q, sec_q;
  logic          wrap;

  always_comb begin
    wrap = (mode_q == MODE_OFF) || (cnt_q == last_of(mode_q));
    if (wrap) begin
      mode_d = mode_req_i;
      cnt_d  = '0;
    end else begin
      mode_d = mode_q;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_OFF;
      cnt_q  <= '0;
      pri_q  <= 1'b0;
      sec_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
      pri_q  <= pri_of(mode_d, cnt_d);
      sec_q  <= sec_of(mode_d, cnt_d);
    end
  end

  assign mode_q_o  = mode_q;
  assign cnt_q_o   = cnt_q;
  assign pri_q_o   = pri_q;
  assign sec_q_o   = sec_q;
  assign x2_next_o = (mode_d == MODE_X2);
endmodule

// File: rtl/clkdiv_outstage.sv
module clkdiv_outstage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic x2_next_i,
  input  logic pri_q_i,
  input  logic sec_q_i,
  input  logic oe_ni,
  output logic pri_o,
  output logic sec_o
);
  logic gate_q;
  logic pri_raw;

  // gate moves only while the reference is low: no clipped pulse
  always_ff @(negedge clk_i or negedge rst_ni)
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= x2_next_i;

  assign pri_raw = pri_q_i | (clk_i & gate_q);
  assign pri_o   = oe_ni ? 1'bz : pri_raw;
  assign sec_o   = oe_ni ? 1'bz : sec_q_i;
endmodule

// File: rtl/clkdiv_pair.sv
module clkdiv_pair
  import clkdiv_pkg::*;
#(
  parameter int HALF_SLOW   = 5,
  parameter int HALF_FAST   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] sel_i,
  input  logic       oe_ni,
  output logic       pri_o,
  output logic       sec_o
);
  localparam int HMAX = (HALF_SLOW > HALF_FAST) ? HALF_SLOW : HALF_FAST;
  localparam int CW   = $clog2(4 * HMAX);

  logic [1:0]    sel_sync;
  mode_e         mode_q;
  logic [CW-1:0] cnt_q;
  logic          pri_q, sec_q, x2_next;

  clkdiv_sync #(.W(2), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sel_i),
    .q_o   (sel_sync)
  );

  clkdiv_core #(.HALF_SLOW(HALF_SLOW), .HALF_FAST(HALF_FAST), .CW(CW)) i_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_req_i(mode_e'(sel_sync)),
    .mode_q_o  (mode_q),
    .cnt_q_o   (cnt_q),
    .pri_q_o   (pri_q),
    .sec_q_o   (sec_q),
    .x2_next_o (x2_next)
  );

  clkdiv_outstage i_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .x2_next_i(x2_next),
    .pri_q_i  (pri_q),
    .sec_q_i  (sec_q),
    .oe_ni    (oe_ni),
    .pri_o    (pri_o),
    .sec_o    (sec_o)
  );
endmodule

// File: rtl/clkdiv_pair_chk.sv
module clkdiv_pair_chk #(
  parameter int HALF_SLOW = 5,
  parameter int HALF_FAST = 3,
  parameter int CW        = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [1:0]    mode_i,
  input logic [CW-1:0] cnt_i,
  input logic          pri_i,
  input logic          sec_i
);
  localparam logic [CW-1:0] END_S = CW'(4 * HALF_SLOW);
  localparam logic [CW-1:0] END_F = CW'(4 * HALF_FAST);

  p_off_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b00) |-> (!pri_i && !sec_i && cnt_i == '0));

  p_slow_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b10) |-> (cnt_i < END_S));

  p_fast_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b11) |-> (cnt_i < END_F));

  p_sec_on_pri_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sec_i) && mode_i != 2'b01) |-> pri_i);

  p_switch_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mode_i) |-> $past(!pri_i && !sec_i));
endmodule

bind clkdiv_pair clkdiv_pair_chk #(
  .HALF_SLOW(HALF_SLOW), .HALF_FAST(HALF_FAST), .CW(CW)
) i_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .mode_i(mode_q),
  .cnt_i (cnt_q),
  .pri_i (pri_q),
  .sec_i (sec_q)
);

// File: tb/test_clkdiv_pair.sv
module test_clkdiv_pair;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] sel = 2'b10;
  logic       oe_n = 1'b0;
  wire        pri_w, sec_w;

  pullup (pri_w);
  pullup (sec_w);

  always #10 clk = ~clk;

  clkdiv_pair i_clkdiv_pair (
    .clk_i (clk),
    .rst_ni(rst_n),
    .sel_i (sel),
    .oe_ni (oe_n),
    .pri_o (pri_w),
    .sec_o (sec_w)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic cap_p [0:255];
  logic cap_s [0:255];

  // code, primary high time in half-reference-cycle samples (0 = stopped)
  typedef struct packed { logic [1:0] sel; logic [7:0] hp; } vec_t;
  localparam vec_t VECS [8] = '{
    '{2'b10, 8'd10}, '{2'b11, 8'd6}, '{2'b01, 8'd1}, '{2'b10, 8'd10},
    '{2'b01, 8'd1},  '{2'b11, 8'd6}, '{2'b00, 8'd0}, '{2'b11, 8'd6}
  };

  task automatic ck(input bit ok, input string req, input string what,
                    input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive_sel(input logic [1:0] s);
    @(negedge clk); #2; sel = s;
  endtask

  task automatic capture(input int n);
    for (int i = 0; i < n; i++) begin
      @(clk); #5;
      cap_p[i] = pri_w;
      cap_s[i] = sec_w;
    end
  endtask

  // R2 R3 R4 R5: phase pattern from a secondary rising edge
  task automatic check_pattern(input string req, input int hp);
    int i0 = -1;
    int errs = 0;
    int fa = 0;
    int fe = 0;
    if (hp == 0) begin
      for (int i = 0; i < 128; i++)
        if (cap_p[i] !== 1'b0 || cap_s[i] !== 1'b0) errs++;
      ck(errs == 0, req, "off outputs not low (samples)", errs, 0);
      return;
    end
    for (int i = 1; i < 48; i++)
      if (i0 < 0 && cap_s[i-1] === 1'b0 && cap_s[i] === 1'b1) i0 = i;
    if (i0 < 0) begin
      ck(0, req, "no secondary rise", 0, 1);
      return;
    end
    for (int k = 0; k < 8 * hp; k++) begin
      logic ep = ((k % (2 * hp)) < hp);
      logic es = ((k % (4 * hp)) < 2 * hp);
      if (cap_p[i0+k] !== ep || cap_s[i0+k] !== es) begin
        if (errs == 0) begin fa = {cap_p[i0+k], cap_s[i0+k]}; fe = {ep, es}; end
        errs++;
      end
    end
    ck(errs == 0, req, "phase pattern {pri,sec}", fa, fe);
  endtask

  function automatic int bad_runs(input bit use_sec, input int n,
                                  input int a, input int b);
    int start = -1;
    int nb = 0;
    for (int i = 1; i < n; i++) begin
      logic x = use_sec ? cap_s[i] : cap_p[i];
      logic y = use_sec ? cap_s[i-1] : cap_p[i-1];
      if (x !== y) begin
        if (start >= 0 && (i - start) != a && (i - start) != b) nb++;
        start = i;
      end
    end
    return nb;
  endfunction

  task automatic switch_case(input logic [1:0] from_s, input logic [1:0] to_s,
                             input int hp_a, input int hp_b, input int lag);
    int nbp, nbs;
    drive_sel(from_s);
    repeat (40) @(posedge clk);
    repeat (lag) @(posedge clk);
    drive_sel(to_s);
    capture(200);
    nbp = bad_runs(1'b0, 200, hp_a, hp_b);
    nbs = bad_runs(1'b1, 200, 2 * hp_a, 2 * hp_b);
    ck(nbp == 0 && nbs == 0, "R7", "odd-length phases across switch", nbp + nbs, 0);
  endtask

  task automatic first_rise(input string req, input logic [1:0] s);
    int kp = 0;
    int ks = 0;
    for (int k = 1; k <= 8; k++) begin
      @(posedge clk); #5;
      if (kp == 0 && pri_w === 1'b1) kp = k;
      if (ks == 0 && sec_w === 1'b1) ks = k;
    end
    ck(kp == 3, req, $sformatf("primary first rise edge, code %0d", s), kp, 3);
    ck(ks == 3, req, $sformatf("secondary first rise edge, code %0d", s), ks, 3);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      ck(0, "WDOG", "watchdog expired", 0, 1);
      finish_run();
    end
  end

  initial begin
    int errs;
    // R9 reset state
    repeat (4) @(posedge clk); #5;
    ck(pri_w === 1'b0 && sec_w === 1'b0, "R9", "outputs during reset",
       {pri_w, sec_w}, 0);
    @(negedge clk); #2; rst_n = 1'b1;

    // vector walk: R1 R2 R3 R4 R5
    foreach (VECS[v]) begin
      drive_sel(VECS[v].sel);
      repeat (30) @(posedge clk);
      capture(128);
      check_pattern(VECS[v].sel == 2'b00 ? "R1" :
                    VECS[v].sel == 2'b01 ? "R2" :
                    VECS[v].sel == 2'b10 ? "R3" : "R4", VECS[v].hp);
    end

    // R6: released pins read the pull-up, even where driven level would be 0
    drive_sel(2'b11);
    repeat (30) @(posedge clk);
    oe_n = 1'b1;
    capture(40);
    errs = 0;
    for (int i = 0; i < 40; i++) if (cap_p[i] !== 1'b1 || cap_s[i] !== 1'b1) errs++;
    ck(errs == 0, "R6", "high impedance while running (samples)", errs, 0);
    drive_sel(2'b00);
    repeat (30) @(posedge clk);
    capture(40);
    errs = 0;
    for (int i = 0; i < 40; i++) if (cap_p[i] !== 1'b1 || cap_s[i] !== 1'b1) errs++;
    ck(errs == 0, "R6", "high impedance while off (samples)", errs, 0);
    oe_n = 1'b0;
    capture(40);
    errs = 0;
    for (int i = 0; i < 40; i++) if (cap_p[i] !== 1'b0 || cap_s[i] !== 1'b0) errs++;
    ck(errs == 0, "R1", "off outputs low once enabled (samples)", errs, 0);

    // R8: leaving off state
    drive_sel(2'b10);
    first_rise("R8", 2'b10);
    drive_sel(2'b00);
    repeat (30) @(posedge clk);
    drive_sel(2'b01);
    first_rise("R8", 2'b01);

    // R7: switches at arbitrary points
    switch_case(2'b10, 2'b11, 10, 6, 7);
    switch_case(2'b11, 2'b01, 6, 1, 2);
    switch_case(2'b01, 2'b10, 1, 10, 1);

    // R9: asynchronous reset mid-run
    drive_sel(2'b10);
    repeat (33) @(posedge clk);
    #7 rst_n = 1'b0;
    #1;
    ck(pri_w === 1'b0 && sec_w === 1'b0, "R9", "outputs right after reset",
       {pri_w, sec_w}, 0);
    capture(12);
    errs = 0;
    for (int i = 0; i < 12; i++) if (cap_p[i] !== 1'b0 || cap_s[i] !== 1'b0) errs++;
    ck(errs == 0, "R9", "outputs held low in reset (samples)", errs, 0);
    @(negedge clk); #2; rst_n = 1'b1;
    first_rise("R9", 2'b10);

    done = 1;
    finish_run();
  end
endmodule